// File: doc/BRIEF.md
# Circular Command Queue Engine

This block is the register-facing front end of an interrupt translation unit's command queue. Software describes a ring in memory through a 64-bit base register: a 4 KiB aligned start address and a count of pages. Software then moves a write offset forward. While enabled, the engine reads each 32-byte command at base plus read offset and hands it downstream on a valid/ready stream. After each handshake it advances the read offset, wrapping to zero at the end of the ring, and it keeps going until the two offsets meet.

A write offset that arrives while the engine is busy only moves the target, and the current run absorbs it. A memory error during a fetch pulls the write offset back onto the read offset, which leaves the queue empty and idle. Software can tell the engine is idle from a quiescent bit. A one-cycle pulse marks each moment the engine is switched on.

Top module: `cmdq_engine`

## Requirements
- R1: After reset, offset 0x00 reads 0x8000_0000 and offsets 0x08, 0x0C, 0x10 and 0x18 read zero. cmd_valid and mem_req_valid are low.
- R2: The base register is held as 64 stored bits, with the low half at offset 0x08 and the high half at 0x0C. Bits [7:0] give a ring size of (value+1)*4096 bytes. The command at read offset X is fetched from address {bits[47:12], 12'h000} + X, and the read offset wraps from (size-32) to zero.
- R3: Writes to either half of the base register leave it unchanged while control bit 0 is 1. Every base write, stored or not, sets the read offset to zero.
- R4: The write offset is at 0x10 and the read offset at 0x18. Only bits [19:5] are kept and all other bits read zero. Offsets 0x14 and 0x1C read zero and ignore writes. Writes to 0x18 have no effect.
- R5: A write to 0x10 whose masked offset is larger than the ring size in bytes is discarded. The write offset does not change and no command is fetched.
- R6: Each command is one memory request (mem_req_valid/mem_req_ready) followed by four response beats. Beat k lands in cmd_data[64k+63:64k]. The command goes out on cmd_valid/cmd_ready, the read offset grows by 32 only after that handshake, and fetching stops when the read offset equals the write offset.
- R7: Once cmd_valid is high, it stays high and cmd_data stays unchanged until cmd_ready is seen.
- R8: A write offset update accepted during a run retargets that run, and all commands up to the new offset are delivered.
- R9: If any of a command's four beats carries mem_rsp_err, the command is not delivered. The write offset becomes equal to the read offset and the engine stops.
- R10: At offset 0x00, bit 0 is a read/write enable and bit 31 reads 1 only when no fetch is in progress and the two offsets are equal. A write that sets bit 0 while it was 0 makes enable_pulse high for exactly the next cycle, and a write that finds bit 0 already set gives no pulse.
- R11: A new fetch starts only while bit 0 of offset 0x00 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| enable_pulse | output | 1 | One-cycle pulse when the engine is switched on |
| mem_req_valid | output | 1 | Command fetch request |
| mem_req_addr | output | 48 | Byte address of the command |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_rsp_valid | input | 1 | Response beat valid |
| mem_rsp_data | input | 64 | Response beat data |
| mem_rsp_err | input | 1 | Response beat error |
| cmd_valid | output | 1 | Command available downstream |
| cmd_data | output | 256 | Command, beat 0 in the low bits |
| cmd_ready | input | 1 | Downstream accepts the command |

## Verification
The checker watches several rules on every cycle. A stalled command and a stalled memory request must hold their values. Request addresses must be 32-byte aligned. The enable pulse must last one cycle and may appear only while the engine is enabled. A fetch may begin only after a cycle in which the engine was enabled. Only the bench scenarios can show the behaviour that depends on sequences: ring wrap-around, base lockout and read-offset clearing, discarded oversized offsets, retargeting during a stalled run, and the collapse of the write offset after a failed fetch.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;
    typedef enum logic [1:0] {
        F_IDLE = 2'd0,
        F_REQ  = 2'd1,
        F_BEAT = 2'd2,
        F_SEND = 2'd3
    } fetch_state_e;

    localparam int BASE_REG_W = 64;

    localparam logic [7:0] OFS_CTRL    = 8'h00;
    localparam logic [7:0] OFS_BASE_LO = 8'h08;
    localparam logic [7:0] OFS_BASE_HI = 8'h0C;
    localparam logic [7:0] OFS_WPTR_LO = 8'h10;
    localparam logic [7:0] OFS_RPTR_LO = 8'h18;
endpackage

// File: rtl/cmdq_regs.sv
module cmdq_regs
    import cmdq_pkg::*;
#(
    parameter int ADDR_W     = 48,
    parameter int PAGE_W     = 8,
    parameter int PAGE_SHIFT = 12,
    parameter int PTR_LO     = 5,
    parameter int PTR_HI     = 19,
    localparam int IDX_W     = PTR_HI - PTR_LO + 1,
    localparam int SIZE_W    = PAGE_W + PAGE_SHIFT - PTR_LO + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [7:0]        addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    input  logic [IDX_W-1:0]  rptr_idx,
    input  logic              fetch_idle,
    input  logic              err_collapse,
    output logic              en,
    output logic              enable_pulse,
    output logic              base_touch,
    output logic [ADDR_W-1:0] base_addr,
    output logic [SIZE_W-1:0] size_cmds,
    output logic [IDX_W-1:0]  wptr_idx
);
    typedef struct packed {
        logic                  en;
        logic                  pulse;
        logic [BASE_REG_W-1:0] base;
        logic [IDX_W-1:0]      wptr;
    } regs_t;

    regs_t q, d;
    logic  quiet;

    assign size_cmds = (SIZE_W'(q.base[PAGE_W-1:0]) + SIZE_W'(1)) << (PAGE_SHIFT - PTR_LO);
    assign base_addr = {q.base[ADDR_W-1:PAGE_SHIFT], {PAGE_SHIFT{1'b0}}};
    assign quiet     = fetch_idle && (rptr_idx == q.wptr);

    always_comb begin
        d          = q;
        d.pulse    = 1'b0;
        base_touch = 1'b0;
        if (wr_en) begin
            case (addr)
                OFS_CTRL: begin
                    d.en    = wdata[0];
                    d.pulse = wdata[0] & ~q.en;
                end
                OFS_BASE_LO: begin
                    base_touch = 1'b1;
                    if (!q.en) d.base[31:0] = wdata;
                end
                OFS_BASE_HI: begin
                    base_touch = 1'b1;
                    if (!q.en) d.base[63:32] = wdata;
                end
                OFS_WPTR_LO: begin
                    if (SIZE_W'(wdata[PTR_HI:PTR_LO]) <= size_cmds)
                        d.wptr = wdata[PTR_HI:PTR_LO];
                end
                default: ;
            endcase
        end
        if (err_collapse) d.wptr = rptr_idx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        case (addr)
            OFS_CTRL:    rdata = {quiet, 30'b0, q.en};
            OFS_BASE_LO: rdata = q.base[31:0];
            OFS_BASE_HI: rdata = q.base[63:32];
            OFS_WPTR_LO: rdata = 32'({q.wptr, {PTR_LO{1'b0}}});
            OFS_RPTR_LO: rdata = 32'({rptr_idx, {PTR_LO{1'b0}}});
            default:     rdata = 32'b0;
        endcase
    end

    assign en           = q.en;
    assign enable_pulse = q.pulse;
    assign wptr_idx     = q.wptr;
endmodule

// File: rtl/cmdq_fetch.sv
module cmdq_fetch
    import cmdq_pkg::*;
#(
    parameter int ADDR_W     = 48,
    parameter int PAGE_W     = 8,
    parameter int PAGE_SHIFT = 12,
    parameter int PTR_LO     = 5,
    parameter int PTR_HI     = 19,
    parameter int BEATS      = 4,
    parameter int BEAT_W     = 64,
    localparam int IDX_W     = PTR_HI - PTR_LO + 1,
    localparam int SIZE_W    = PAGE_W + PAGE_SHIFT - PTR_LO + 1,
    localparam int CNT_W     = (BEATS > 1) ? $clog2(BEATS) : 1,
    localparam int CMD_W     = BEATS * BEAT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [SIZE_W-1:0] size_cmds,
    input  logic [IDX_W-1:0]  wptr_idx,
    input  logic              clr_rptr,
    output logic [IDX_W-1:0]  rptr_idx,
    output logic              idle,
    output logic              err_collapse,
    output logic              mem_req_valid,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_req_ready,
    input  logic              mem_rsp_valid,
    input  logic [BEAT_W-1:0] mem_rsp_data,
    input  logic              mem_rsp_err,
    output logic              cmd_valid,
    output logic [CMD_W-1:0]  cmd_data,
    input  logic              cmd_ready
);
    typedef struct packed {
        fetch_state_e     state;
        logic [CNT_W-1:0] cnt;
        logic             err;
        logic [CMD_W-1:0] data;
        logic [IDX_W-1:0] rptr;
    } fetch_t;

    fetch_t q, d;
    logic [SIZE_W-1:0] rptr_inc;
    logic [IDX_W-1:0]  rptr_next;

    assign rptr_inc  = SIZE_W'(q.rptr) + SIZE_W'(1);
    assign rptr_next = (rptr_inc == size_cmds) ? '0 : rptr_inc[IDX_W-1:0];

    always_comb begin
        d            = q;
        err_collapse = 1'b0;
        case (q.state)
            F_IDLE: begin
                if (en && (q.rptr != wptr_idx)) begin
                    d.state = F_REQ;
                    d.cnt   = '0;
                    d.err   = 1'b0;
                end
            end
            F_REQ: begin
                if (mem_req_ready) d.state = F_BEAT;
            end
            F_BEAT: begin
                if (mem_rsp_valid) begin
                    d.data[q.cnt*BEAT_W +: BEAT_W] = mem_rsp_data;
                    d.err = q.err | mem_rsp_err;
                    d.cnt = q.cnt + 1'b1;
                    if (q.cnt == CNT_W'(BEATS - 1)) begin
                        if (q.err | mem_rsp_err) begin
                            d.state      = F_IDLE;
                            err_collapse = 1'b1;
                        end else begin
                            d.state = F_SEND;
                        end
                    end
                end
            end
            F_SEND: begin
                if (cmd_ready) begin
                    d.rptr  = rptr_next;
                    d.state = F_IDLE;
                end
            end
            default: d.state = F_IDLE;
        endcase
        if (clr_rptr) d.rptr = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rptr_idx      = q.rptr;
    assign idle          = (q.state == F_IDLE);
    assign mem_req_valid = (q.state == F_REQ);
    assign mem_req_addr  = base_addr + ADDR_W'({q.rptr, {PTR_LO{1'b0}}});
    assign cmd_valid     = (q.state == F_SEND);
    assign cmd_data      = q.data;
endmodule

// File: rtl/cmdq_engine.sv
module cmdq_engine #(
    parameter int ADDR_W     = 48,
    parameter int PAGE_W     = 8,
    parameter int PAGE_SHIFT = 12,
    parameter int PTR_LO     = 5,
    parameter int PTR_HI     = 19,
    parameter int BEATS      = 4,
    parameter int BEAT_W     = 64,
    localparam int IDX_W     = PTR_HI - PTR_LO + 1,
    localparam int SIZE_W    = PAGE_W + PAGE_SHIFT - PTR_LO + 1,
    localparam int CMD_W     = BEATS * BEAT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [7:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              enable_pulse,
    output logic              mem_req_valid,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_req_ready,
    input  logic              mem_rsp_valid,
    input  logic [BEAT_W-1:0] mem_rsp_data,
    input  logic              mem_rsp_err,
    output logic              cmd_valid,
    output logic [CMD_W-1:0]  cmd_data,
    input  logic              cmd_ready
);
    logic              ctrl_en;
    logic              base_touch;
    logic              fetch_idle;
    logic              err_collapse;
    logic [ADDR_W-1:0] base_addr;
    logic [SIZE_W-1:0] size_cmds;
    logic [IDX_W-1:0]  wptr_idx;
    logic [IDX_W-1:0]  rptr_idx;

    cmdq_regs #(
        .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .PAGE_SHIFT(PAGE_SHIFT),
        .PTR_LO(PTR_LO), .PTR_HI(PTR_HI)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(reg_wr_en), .addr(reg_addr), .wdata(reg_wdata), .rdata(reg_rdata),
        .rptr_idx(rptr_idx), .fetch_idle(fetch_idle), .err_collapse(err_collapse),
        .en(ctrl_en), .enable_pulse(enable_pulse), .base_touch(base_touch),
        .base_addr(base_addr), .size_cmds(size_cmds), .wptr_idx(wptr_idx)
    );

    cmdq_fetch #(
        .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .PAGE_SHIFT(PAGE_SHIFT),
        .PTR_LO(PTR_LO), .PTR_HI(PTR_HI), .BEATS(BEATS), .BEAT_W(BEAT_W)
    ) u_fetch (
        .clk(clk), .rst_n(rst_n),
        .en(ctrl_en), .base_addr(base_addr), .size_cmds(size_cmds),
        .wptr_idx(wptr_idx), .clr_rptr(base_touch),
        .rptr_idx(rptr_idx), .idle(fetch_idle), .err_collapse(err_collapse),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_req_ready(mem_req_ready), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .mem_rsp_err(mem_rsp_err),
        .cmd_valid(cmd_valid), .cmd_data(cmd_data), .cmd_ready(cmd_ready)
    );
endmodule

// File: rtl/cmdq_engine_chk.sv
module cmdq_engine_chk #(
    parameter int ADDR_W = 48,
    parameter int PTR_LO = 5,
    parameter int CMD_W  = 256
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic [CMD_W-1:0]  cmd_data,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic              enable_pulse,
    input logic              ctrl_en
);
    // R7
    cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_data));

    // R6
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

    // R6
    req_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (mem_req_addr[PTR_LO-1:0] == '0));

    // R10
    pulse_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        enable_pulse |=> !enable_pulse);

    // R10
    pulse_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        enable_pulse |-> ctrl_en);

    // R11
    req_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req_valid) |-> $past(ctrl_en));
endmodule

bind cmdq_engine cmdq_engine_chk #(
    .ADDR_W(ADDR_W), .PTR_LO(PTR_LO), .CMD_W(CMD_W)
) u_chk (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .enable_pulse(enable_pulse), .ctrl_en(ctrl_en)
);

// File: tb/cmdq_engine_tb.sv
`timescale 1ns/1ps
module cmdq_engine_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         reg_wr_en = 1'b0;
    logic [7:0]   reg_addr = 8'h00;
    logic [31:0]  reg_wdata = 32'h0;
    logic [31:0]  reg_rdata;
    logic         enable_pulse;
    logic         mem_req_valid;
    logic [47:0]  mem_req_addr;
    logic         mem_req_ready = 1'b1;
    logic         mem_rsp_valid = 1'b0;
    logic [63:0]  mem_rsp_data = 64'h0;
    logic         mem_rsp_err = 1'b0;
    logic         cmd_valid;
    logic [255:0] cmd_data;
    logic         cmd_ready = 1'b1;

    int checks = 0;
    int errors = 0;
    int n_cmds = 0;
    int cycles = 0;

    logic [47:0] exp_base = 48'h0;
    int          exp_rptr = 0;
    int          exp_size = 128;
    logic [47:0] err_addr = 48'h0;
    logic [47:0] mb_addr = 48'h0;
    int          mb_left = 0;

    always #10 clk = ~clk;

    cmdq_engine u_dut (
        .clk(clk), .rst_n(rst_n),
        .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .enable_pulse(enable_pulse),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_req_ready(mem_req_ready), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .mem_rsp_err(mem_rsp_err),
        .cmd_valid(cmd_valid), .cmd_data(cmd_data), .cmd_ready(cmd_ready)
    );

    function automatic logic [63:0] beat_word(input logic [47:0] a, input int k);
        return {32'hA500_0000 | 32'(k), a[31:0]};
    endfunction

    function automatic logic [255:0] exp_cmd(input logic [47:0] a);
        logic [255:0] v;
        for (int k = 0; k < 4; k++) v[k*64 +: 64] = beat_word(a, k);
        return v;
    endfunction

    task automatic check(input string req, input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // memory model: four beats after each request
    always @(negedge clk) begin
        if (!rst_n) begin
            mb_left       = 0;
            mem_rsp_valid = 1'b0;
            mem_rsp_err   = 1'b0;
        end else if (mb_left > 0) begin
            mem_rsp_valid = 1'b1;
            mem_rsp_data  = beat_word(mb_addr, 4 - mb_left);
            mem_rsp_err   = (mb_addr == err_addr);
            mb_left--;
        end else begin
            mem_rsp_valid = 1'b0;
            mem_rsp_err   = 1'b0;
            if (mem_req_valid) begin
                mb_addr = mem_req_addr;
                mb_left = 4;
            end
        end
    end

    // command monitor with an independent ring model
    always @(negedge clk) begin
        if (rst_n && cmd_valid && cmd_ready) begin
            check("R6 command content/address", cmd_data, exp_cmd(exp_base + 48'(exp_rptr * 32)));
            n_cmds++;
            exp_rptr = (exp_rptr + 1 == exp_size) ? 0 : exp_rptr + 1;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            checks++;
            $display("FAIL R6 watchdog actual=%0d expected=<150000", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] v);
        @(posedge clk); #2;
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = v;
        @(posedge clk); #2;
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        @(posedge clk); #2;
        reg_addr = a;
        @(negedge clk);
        v = reg_rdata;
    endtask

    task automatic wait_quiet();
        logic [31:0] v;
        for (int i = 0; i < 5000; i++) begin
            rd(8'h00, v);
            if (v[31]) break;
        end
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(8'h00, v); check("R1 ctrl", 256'(v), 256'h8000_0000);
        rd(8'h08, v); check("R1 base lo", 256'(v), 256'h0);
        rd(8'h10, v); check("R1 wptr", 256'(v), 256'h0);
        rd(8'h18, v); check("R1 rptr", 256'(v), 256'h0);
        check("R1 cmd_valid", 256'(cmd_valid), 256'h0);
        check("R1 mem_req_valid", 256'(mem_req_valid), 256'h0);
    endtask

    task automatic t_base_and_enable();
        logic [31:0] v;
        wr(8'h08, 32'h3456_7000);
        wr(8'h0C, 32'h0000_0012);
        exp_base = 48'h12_3456_7000; exp_rptr = 0; exp_size = 128;
        rd(8'h08, v); check("R2 base lo", 256'(v), 256'h3456_7000);
        rd(8'h0C, v); check("R2 base hi", 256'(v), 256'h12);
        wr(8'h00, 32'h1);
        @(negedge clk); check("R10 pulse high", 256'(enable_pulse), 256'h1);
        @(negedge clk); check("R10 pulse one cycle", 256'(enable_pulse), 256'h0);
        wr(8'h00, 32'h1);
        @(negedge clk); check("R10 no pulse when already on", 256'(enable_pulse), 256'h0);
        rd(8'h00, v); check("R10 ctrl enabled quiet", 256'(v), 256'h8000_0001);
        wr(8'h08, 32'h0000_9003);
        rd(8'h08, v); check("R3 base locked", 256'(v), 256'h3456_7000);
    endtask

    task automatic t_run_and_mask();
        logic [31:0] v;
        int n0;
        n0 = n_cmds;
        wr(8'h10, 32'h60);
        wait_quiet();
        check("R6 three commands", 256'(n_cmds - n0), 256'd3);
        rd(8'h18, v); check("R6 rptr after run", 256'(v), 256'h60);
        n0 = n_cmds;
        wr(8'h10, 32'h0000_009F);
        wait_quiet();
        rd(8'h10, v); check("R4 wptr masked", 256'(v), 256'h80);
        check("R4 masked write one command", 256'(n_cmds - n0), 256'd1);
        wr(8'h14, 32'hFFFF_FFFF);
        rd(8'h14, v); check("R4 wptr upper zero", 256'(v), 256'h0);
        wr(8'h18, 32'h40);
        rd(8'h18, v); check("R4 rptr read-only", 256'(v), 256'h80);
        rd(8'h1C, v); check("R4 rptr upper zero", 256'(v), 256'h0);
    endtask

    task automatic t_stall_retarget();
        logic [31:0] v;
        int n0;
        n0 = n_cmds;
        @(posedge clk); #2; cmd_ready = 1'b0;
        wr(8'h10, 32'hA0);
        repeat (20) @(negedge clk);
        check("R7 valid held", 256'(cmd_valid), 256'h1);
        rd(8'h18, v); check("R6 no advance before handshake", 256'(v), 256'h80);
        rd(8'h00, v); check("R10 busy not quiet", 256'(v[31]), 256'h0);
        wr(8'h10, 32'hE0);
        @(posedge clk); #2; cmd_ready = 1'b1;
        wait_quiet();
        check("R8 retargeted run count", 256'(n_cmds - n0), 256'd3);
        rd(8'h18, v); check("R8 rptr reaches new target", 256'(v), 256'hE0);
    endtask

    task automatic t_discard();
        logic [31:0] v;
        int n0;
        n0 = n_cmds;
        wr(8'h10, 32'h2000);
        repeat (20) @(negedge clk);
        rd(8'h10, v); check("R5 oversized wptr kept old", 256'(v), 256'hE0);
        check("R5 no fetch", 256'(n_cmds - n0), 256'd0);
    endtask

    task automatic t_disabled_and_base();
        logic [31:0] v;
        int n0;
        n0 = n_cmds;
        wr(8'h00, 32'h0);
        wr(8'h10, 32'h100);
        repeat (30) @(negedge clk);
        check("R11 no commands while disabled", 256'(n_cmds - n0), 256'd0);
        rd(8'h00, v); check("R10 pending not quiet", 256'(v), 256'h0);
        wr(8'h08, 32'h3456_8000);
        exp_base = 48'h12_3456_8000; exp_rptr = 0;
        rd(8'h08, v); check("R3 base stored when disabled", 256'(v), 256'h3456_8000);
        rd(8'h18, v); check("R3 base write clears rptr", 256'(v), 256'h0);
        wr(8'h00, 32'h1);
        @(negedge clk); check("R10 pulse on re-enable", 256'(enable_pulse), 256'h1);
        wait_quiet();
        check("R11 commands after enable", 256'(n_cmds - n0), 256'd8);
    endtask

    task automatic t_wrap();
        logic [31:0] v;
        int n0;
        n0 = n_cmds;
        wr(8'h10, 32'hFE0);
        wait_quiet();
        wr(8'h10, 32'h20);
        wait_quiet();
        check("R2 wrap command count", 256'(n_cmds - n0), 256'd121);
        rd(8'h18, v); check("R2 rptr after wrap", 256'(v), 256'h20);
    endtask

    task automatic t_error();
        logic [31:0] v;
        int n0;
        n0 = n_cmds;
        err_addr = exp_base + 48'h40;
        wr(8'h10, 32'h80);
        wait_quiet();
        check("R9 delivered before error", 256'(n_cmds - n0), 256'd1);
        rd(8'h10, v); check("R9 wptr collapsed", 256'(v), 256'h40);
        rd(8'h18, v); check("R9 rptr at failing command", 256'(v), 256'h40);
        err_addr = 48'h0;
        n0 = n_cmds;
        wr(8'h10, 32'h60);
        wait_quiet();
        check("R9 recovery", 256'(n_cmds - n0), 256'd1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        t_reset();
        t_base_and_enable();
        t_run_and_mask();
        t_stall_retarget();
        t_discard();
        t_disabled_and_base();
        t_wrap();
        t_error();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule